// File: doc/BRIEF.md
# Data Tenure Beat Sequencer

This block sequences the data phase of one processor-bus transfer after the arbiter has granted the data bus. A one-cycle start pulse captures four things: whether the transfer is a burst, the byte size of a single-beat transfer, the bus-width mode, and the critical starting beat. The sequencer then issues one transfer acknowledge for each beat, on each cycle where the data source or sink reports ready. A cycle without ready becomes a data wait state, and the beat count is kept across it.

A burst always covers one 32-byte line. In 64-bit mode that is four double-word beats. In 32-bit mode it is eight word beats. A single-beat transfer moves 1 to 8 bytes with one acknowledge. For each beat the block drives a beat index that wraps from the critical beat, so the beat address can be formed. It raises a last-beat flag to the arbiter together with the final acknowledge. A single-beat request whose size cannot travel in the selected width is turned away with a one-cycle size-error pulse.

The state machine has four states:
- IDLE waits for a start.
- SINGLE runs one beat.
- BURST runs the beats of a line.
- REJECT drives the error pulse.

Its transitions are:
- IDLE→SINGLE on a start with no burst and a legal size.
- IDLE→BURST on a start with burst set.
- IDLE→REJECT on a start with no burst and an illegal size.
- SINGLE→IDLE on a ready cycle.
- BURST→IDLE on a ready cycle at the final beat.
- REJECT→IDLE always.
- Every other case holds the current state.

Top module: `data_beat_seq`

## Requirements
- R1: After reset `busy_o`, `ta_o`, `last_o` and `size_err_o` are 0 and `beat_idx_o` is 0.
- R2: A start with `burst_i`=0 and a legal size (`size_i` is the byte count in binary: 1 to 8 when `wide_i`=1, 1 to 4 when `wide_i`=0) produces exactly one acknowledge, and `busy_o` is 1 from the cycle after the start until that acknowledge.
- R3: A start with `burst_i`=1 produces exactly 4 acknowledges when `wide_i`=1 (64-bit mode) and exactly 8 when `wide_i`=0 (32-bit mode).
- R4: `ta_o` is 1 exactly on busy cycles where `ready_i` is 1. A cycle with `ready_i`=0 is a wait state: it keeps the beat count and `beat_idx_o`.
- R5: `last_o` is 1 only together with the final acknowledge of a transfer.
- R6: On the cycle after the final acknowledge, `busy_o` is 0 and the block accepts a new start.
- R7: On the acknowledge of beat n (counted from 0), `beat_idx_o` equals (`crit_i` + n) mod B. B is 4 in 64-bit mode and 8 in 32-bit mode. `crit_i` is sampled at the start, and for a single beat n=0.
- R8: A start with `burst_i`=0 and a size that is 0, above 8, or above 4 in 32-bit mode gives `size_err_o`=1 for exactly the next cycle. That cycle has no acknowledge and `busy_o`=0, and the block returns to idle. With `burst_i`=1 the size is ignored.
- R9: `start_i` and the other request inputs are ignored while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of a granted data tenure (sampled when idle) |
| burst_i | input | 1 | 1 = burst transfer |
| size_i | input | 4 | Single-beat byte count, binary |
| wide_i | input | 1 | 1 = 64-bit data mode, 0 = 32-bit |
| crit_i | input | 3 | Critical (first) beat of the line |
| ready_i | input | 1 | Data source/sink ready this cycle |
| ta_o | output | 1 | Transfer acknowledge for the current beat |
| last_o | output | 1 | Final acknowledge of the tenure |
| busy_o | output | 1 | Data tenure in progress |
| size_err_o | output | 1 | Illegal single-beat size rejected |
| beat_idx_o | output | 3 | Wrapped index of the current beat |

## Verification
The bench sweeps every combination of the following:
- both width modes;
- burst and single;
- byte sizes 0 to 9 and 15;
- all eight critical beats;
- three ready patterns: always ready, alternating, and two-of-three.

The always-ready pattern exposes a wrong beat count or a misplaced last flag. The waiting patterns separate a design that keeps the count across wait states from one that advances or acknowledges without ready. The size sweep at the 4/5 and 8/9 edges in each mode shows whether the legality rule depends on the width mode and whether bursts ignore size. Start pulses carrying an illegal size are injected during transfers to show that they are ignored.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SINGLE = 2'd1,
        ST_BURST  = 2'd2,
        ST_REJECT = 2'd3
    } dts_state_e;

endpackage

// File: rtl/dts_req_decode.sv
module dts_req_decode #(
    parameter int NARROW_BYTES = 4,
    parameter int WIDE_BYTES   = 8,
    parameter int LINE_BYTES   = 32,
    parameter int SIZEW        = 4,
    parameter int IDXW         = 3
) (
    input  logic             burst_i,
    input  logic             wide_i,
    input  logic [SIZEW-1:0] size_i,
    output logic             legal_o,
    output logic [IDXW-1:0]  final_cnt_o,
    output logic [IDXW-1:0]  idx_mask_o
);
    localparam int NARROW_BEATS = LINE_BYTES / NARROW_BYTES;
    localparam int WIDE_BEATS   = LINE_BYTES / WIDE_BYTES;

    logic size_nonzero;
    logic size_fits;

    always_comb begin
        size_nonzero = (size_i != '0);
        if (wide_i) begin
            size_fits = (size_i <= SIZEW'(WIDE_BYTES));
        end else begin
            size_fits = (size_i <= SIZEW'(NARROW_BYTES));
        end
        legal_o = burst_i | (size_nonzero & size_fits);

        if (wide_i) begin
            idx_mask_o = IDXW'(WIDE_BEATS - 1);
        end else begin
            idx_mask_o = IDXW'(NARROW_BEATS - 1);
        end

        if (!burst_i) begin
            final_cnt_o = '0;
        end else if (wide_i) begin
            final_cnt_o = IDXW'(WIDE_BEATS - 1);
        end else begin
            final_cnt_o = IDXW'(NARROW_BEATS - 1);
        end
    end

endmodule

// File: rtl/dts_beat_ctr.sv
module dts_beat_ctr #(
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            adv_i,
    input  logic [IDXW-1:0] crit_i,
    input  logic [IDXW-1:0] mask_i,
    input  logic [IDXW-1:0] final_cnt_i,
    output logic            final_o,
    output logic [IDXW-1:0] idx_o
);
    logic [IDXW-1:0] cnt_q;
    logic [IDXW-1:0] base_q;
    logic [IDXW-1:0] mask_q;
    logic [IDXW-1:0] final_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            final_q <= '0;
        end else if (load_i) begin
            cnt_q   <= '0;
            base_q  <= crit_i & mask_i;
            mask_q  <= mask_i;
            final_q <= final_cnt_i;
        end else if (adv_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign final_o = (cnt_q == final_q);
    assign idx_o   = (base_q + cnt_q) & mask_q;

endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
    import dts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic burst_i,
    input  logic legal_i,
    input  logic ready_i,
    input  logic final_i,
    output logic load_o,
    output logic ta_o,
    output logic last_o,
    output logic busy_o,
    output logic err_o
);
    dts_state_e state_q;
    dts_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (!legal_i) begin
                        state_d = ST_REJECT;
                    end else if (burst_i) begin
                        state_d = ST_BURST;
                    end else begin
                        state_d = ST_SINGLE;
                    end
                end
            end
            ST_SINGLE: begin
                if (ready_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_BURST: begin
                if (ready_i && final_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        ta_o   = 1'b0;
        last_o = 1'b0;
        busy_o = 1'b0;
        err_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i & legal_i;
            end
            ST_SINGLE: begin
                busy_o = 1'b1;
                ta_o   = ready_i;
                last_o = ready_i;
            end
            ST_BURST: begin
                busy_o = 1'b1;
                ta_o   = ready_i;
                last_o = ready_i & final_i;
            end
            ST_REJECT: begin
                err_o = 1'b1;
            end
            default: begin
                err_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/data_beat_seq.sv
module data_beat_seq #(
    parameter int NARROW_BYTES = 4,
    parameter int WIDE_BYTES   = 8,
    parameter int LINE_BYTES   = 32,
    parameter int SIZEW        = $clog2(WIDE_BYTES + 1),
    parameter int IDXW         = $clog2(LINE_BYTES / NARROW_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             burst_i,
    input  logic [SIZEW-1:0] size_i,
    input  logic             wide_i,
    input  logic [IDXW-1:0]  crit_i,
    input  logic             ready_i,
    output logic             ta_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             size_err_o,
    output logic [IDXW-1:0]  beat_idx_o
);
    logic            legal;
    logic [IDXW-1:0] final_cnt;
    logic [IDXW-1:0] idx_mask;
    logic            load;
    logic            at_final;

    dts_req_decode #(
        .NARROW_BYTES (NARROW_BYTES),
        .WIDE_BYTES   (WIDE_BYTES),
        .LINE_BYTES   (LINE_BYTES),
        .SIZEW        (SIZEW),
        .IDXW         (IDXW)
    ) u_decode (
        .burst_i     (burst_i),
        .wide_i      (wide_i),
        .size_i      (size_i),
        .legal_o     (legal),
        .final_cnt_o (final_cnt),
        .idx_mask_o  (idx_mask)
    );

    dts_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .burst_i (burst_i),
        .legal_i (legal),
        .ready_i (ready_i),
        .final_i (at_final),
        .load_o  (load),
        .ta_o    (ta_o),
        .last_o  (last_o),
        .busy_o  (busy_o),
        .err_o   (size_err_o)
    );

    dts_beat_ctr #(
        .IDXW (IDXW)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .adv_i       (ta_o),
        .crit_i      (crit_i),
        .mask_i      (idx_mask),
        .final_cnt_i (final_cnt),
        .final_o     (at_final),
        .idx_o       (beat_idx_o)
    );

endmodule

// File: rtl/data_beat_seq_chk.sv
module data_beat_seq_chk #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ready_i,
    input logic            ta_o,
    input logic            last_o,
    input logic            busy_o,
    input logic            size_err_o,
    input logic [IDXW-1:0] beat_idx_o
);
    logic [IDXW:0] acks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acks_q <= '0;
        end else if (!busy_o) begin
            acks_q <= '0;
        end else if (ta_o) begin
            acks_q <= acks_q + 1'b1;
        end
    end

    // R4
    ta_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ta_o |-> (ready_i && busy_o));

    // R4
    wait_holds_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(ta_o)) |-> $stable(beat_idx_o));

    // R5
    last_with_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> ta_o);

    // R6
    idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !busy_o);

    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_err_o |-> (!ta_o && !busy_o));

    // R8
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_err_o |=> !size_err_o);

    // R3
    beat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acks_q <= (IDXW + 1)'(1 << IDXW));

endmodule

bind data_beat_seq data_beat_seq_chk #(.IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready_i),
    .ta_o       (ta_o),
    .last_o     (last_o),
    .busy_o     (busy_o),
    .size_err_o (size_err_o),
    .beat_idx_o (beat_idx_o)
);

// File: tb/tb_data_beat_seq.sv
`timescale 1ns/1ps
module tb_data_beat_seq;
    logic       clk;
    logic       rst_n;
    logic       start_i;
    logic       burst_i;
    logic [3:0] size_i;
    logic       wide_i;
    logic [2:0] crit_i;
    logic       ready_i;
    logic       ta_o;
    logic       last_o;
    logic       busy_o;
    logic       size_err_o;
    logic [2:0] beat_idx_o;

    int tests;
    int fails;
    int cycles;
    bit done;

    data_beat_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .burst_i    (burst_i),
        .size_i     (size_i),
        .wide_i     (wide_i),
        .crit_i     (crit_i),
        .ready_i    (ready_i),
        .ta_o       (ta_o),
        .last_o     (last_o),
        .busy_o     (busy_o),
        .size_err_o (size_err_o),
        .beat_idx_o (beat_idx_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog expired, actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit rdy_pat(input int pat, input int c);
        if (pat == 0) return 1'b1;
        if (pat == 1) return (c % 2) == 1;
        return (c % 3) != 0;
    endfunction

    task automatic run(input bit w, input bit b, input int sz, input int crit, input int pat);
        bit legal;
        int nb;
        int mask;
        int n;
        int c;
        legal = b || (sz >= 1 && sz <= (w ? 8 : 4));
        nb    = b ? (w ? 4 : 8) : 1;
        mask  = w ? 3 : 7;
        @(negedge clk);
        start_i = 1'b1; burst_i = b; wide_i = w;
        size_i = 4'(sz); crit_i = 3'(crit); ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        if (!legal) begin
            #1;
            chk(size_err_o === 1'b1, "R8 err pulse", size_err_o, 1);
            chk(busy_o === 1'b0 && ta_o === 1'b0, "R8 no beat", busy_o, 0);
            @(negedge clk);
            #1;
            chk(size_err_o === 1'b0 && busy_o === 1'b0, "R8 back idle", size_err_o, 0);
            return;
        end
        chk(size_err_o === 1'b0, "R8 legal no err", size_err_o, 0);
        n = 0;
        c = 0;
        while (n < nb && c < 64) begin
            ready_i = rdy_pat(pat, c);
            // R9: stray start with an illegal size during the tenure
            start_i = (c % 2) == 0;
            burst_i = ~b;
            wide_i  = ~w;
            size_i  = 4'd0;
            crit_i  = 3'(crit + 3);
            #1;
            chk(busy_o === 1'b1, "R2 busy in tenure", busy_o, 1);
            chk(ta_o === ready_i, "R4 ta follows ready", ta_o, ready_i);
            if (ready_i) begin
                chk(int'(beat_idx_o) == ((crit + n) & mask), "R7 beat index",
                    beat_idx_o, (crit + n) & mask);
                chk(last_o === (n == nb - 1), "R5 last flag", last_o, n == nb - 1);
                n = n + 1;
            end else begin
                chk(last_o === 1'b0, "R5 no last on wait", last_o, 0);
            end
            c = c + 1;
            @(negedge clk);
        end
        chk(n == nb, (b ? "R3 burst beat count" : "R2 single beat count"), n, nb);
        start_i = 1'b0;
        ready_i = 1'b1;
        #1;
        chk(busy_o === 1'b0 && ta_o === 1'b0, "R6 idle after last (R9 stray start ignored)",
            busy_o, 0);
        ready_i = 1'b0;
    endtask

    initial begin
        tests = 0; fails = 0; cycles = 0; done = 1'b0;
        rst_n = 1'b0; start_i = 1'b0; burst_i = 1'b0; size_i = '0;
        wide_i = 1'b0; crit_i = '0; ready_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(busy_o === 1'b0 && ta_o === 1'b0 && last_o === 1'b0 && size_err_o === 1'b0,
            "R1 reset outputs", busy_o, 0);
        chk(beat_idx_o === 3'd0, "R1 reset index", beat_idx_o, 0);
        rst_n = 1'b1;
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 11; s++) begin
                    for (int cr = 0; cr < 8; cr++) begin
                        for (int p = 0; p < 3; p++) begin
                            run(w[0], b[0], (s == 10) ? 15 : s, cr, p);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule